// File: doc/BRIEF.md
# Power Mode and Reset Sequencer

This block chooses the operating mode of a metering device: full-power running, a battery-backed brownout mode, a low-power sleep mode, and a reset hold. It uses a handful of status flags. These are a main-supply comparator output, a battery-sufficiency flag, the external reset pin, a PLL-lock indication, and a wake request from the real-time clock. From them it drives the enables for the analog/compute domain and the processor. It also selects the processor clock source, holds the processor in reset, and gives a one-cycle pulse that marks the processor boot address as valid.

All sequencing runs on the slow 32.768 kHz crystal clock. The comparator, battery and lock flags are asynchronous to that clock, so each passes through a two-flop synchronizer. The reset pin clears the sequencer asynchronously. After the pin falls, a counter of crystal cycles decides when the processor may leave reset. The analog comparators, the regulator, the PLL and the processor sit outside this block.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_pin_i` is high, `mode_o` reads 2'b11 (reset hold), `cpu_rst_o` and `regs_dflt_o` are 1, and `afe_ce_en_o` and `cpu_en_o` are 0.
- R2: With supply good and PLL locked, `cpu_rst_o` stays 1 through the first 4095 rising crystal edges after `rst_pin_i` falls, and drops at the 4096th.
- R3: When the reset hold ends, `boot_vld_o` is 1 for exactly one cycle, and `boot_addr_o` reads 16'h0000.
- R4: In running mode (`mode_o`=2'b00, analog enabled, processor on the PLL clock with `cpu_clk_xtal_o`=0), a supply loss with the battery good moves the block to brownout. Brownout is `mode_o`=2'b01, analog off, processor enabled, and `cpu_clk_xtal_o`=1.
- R5: A supply loss in running mode with the battery insufficient moves the block to reset hold. The processor is released again 4096 edges after entry, once supply and lock are good. A battery loss alone while the supply is good has no effect.
- R6: In brownout, a battery loss moves the block to sleep (`mode_o`=2'b10), with both the processor and the analog domain disabled.
- R7: Sleep is held until the supply returns with the PLL locked, or until `rtc_wake_i` is seen with the battery good. A wake moves the block to brownout on the next edge.
- R8: The block enters running mode from brownout or sleep only while the synchronized PLL lock is 1. With the supply back but no lock, it stays where it is.
- R9: `sw_sleep_i` moves brownout to sleep on the next crystal edge and is ignored in running mode.
- R10: A change on the supply, battery or lock input reaches `mode_o` on the third rising edge after the change. This covers two synchronizer stages plus the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal_i | input | 1 | Slow crystal clock |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| supply_ok_i | input | 1 | Main-supply comparator: 1 = supply above bias threshold |
| batt_ok_i | input | 1 | Battery sufficient to hold brownout |
| pll_lock_i | input | 1 | PLL settled |
| rtc_wake_i | input | 1 | RTC auto-wake request (crystal domain) |
| sw_sleep_i | input | 1 | Software request to go from brownout to sleep |
| mode_o | output | 2 | 00 running, 01 brownout, 10 sleep, 11 reset hold |
| afe_ce_en_o | output | 1 | Analog front end and compute engine enable |
| cpu_en_o | output | 1 | Processor enable |
| cpu_clk_xtal_o | output | 1 | 1 = processor on crystal clock, 0 = on PLL clock |
| cpu_rst_o | output | 1 | Processor reset |
| regs_dflt_o | output | 1 | Hold memory-mapped I/O registers at defaults |
| boot_vld_o | output | 1 | One-cycle pulse on release from reset hold |
| boot_addr_o | output | 16 | Processor start address |

## Verification
Two corner cases are hard to reach. The first is the reset hold entered from running mode rather than from the pin. It needs the battery flag lowered while the supply is still good, which must leave the mode unchanged, and then the supply removed. The bench then counts the full 4096-edge window from the observed entry. The second is the PLL-lock gate. The bench brings the supply back while lock is held low for many cycles before raising it, so both the blocked case and the three-edge latency of the later transition are measured.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_BROWN = 2'b01,
        MODE_SLEEP = 2'b10,
        MODE_HOLD  = 2'b11
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e mode;
        logic     boot;
    } fsm_state_t;

    typedef struct packed {
        logic afe_ce_en;
        logic cpu_en;
        logic cpu_clk_xtal;
        logic cpu_rst;
        logic regs_dflt;
    } dom_ctrl_t;

endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) pipe_q <= '0;
        else       pipe_q <= pipe_d;
    end

    assign dout_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pms_rst_timer.sv
module pms_rst_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done_o = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)       cnt_d = '0;
        else if (!done_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    // R2: each edge in the hold window advances the count by one
    p_count_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
    import pms_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     supply_s_i,
    input  logic     batt_s_i,
    input  logic     lock_s_i,
    input  logic     rtc_wake_i,
    input  logic     sw_sleep_i,
    input  logic     hold_done_i,
    output pm_mode_e mode_o,
    output logic     boot_o
);
    fsm_state_t st_d, st_q;
    logic       power_back;

    assign power_back = supply_s_i && lock_s_i;

    always_comb begin
        st_d      = st_q;
        st_d.boot = 1'b0;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (!supply_s_i) st_d.mode = batt_s_i ? MODE_BROWN : MODE_HOLD;
            end
            MODE_BROWN: begin
                if (power_back)                  st_d.mode = MODE_RUN;
                else if (!batt_s_i || sw_sleep_i) st_d.mode = MODE_SLEEP;
            end
            MODE_SLEEP: begin
                if (power_back)                   st_d.mode = MODE_RUN;
                else if (rtc_wake_i && batt_s_i)  st_d.mode = MODE_BROWN;
            end
            MODE_HOLD: begin
                if (hold_done_i) begin
                    if (power_back) begin
                        st_d.mode = MODE_RUN;
                        st_d.boot = 1'b1;
                    end else if (!supply_s_i && batt_s_i) begin
                        st_d.mode = MODE_BROWN;
                        st_d.boot = 1'b1;
                    end
                end
            end
            default: st_d.mode = MODE_HOLD;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q.mode <= MODE_HOLD;
            st_q.boot <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign boot_o = st_q.boot;

    p_brown_entry_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.mode == MODE_RUN && !supply_s_i && batt_s_i) |=> (st_q.mode == MODE_BROWN));
    p_hold_entry_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.mode == MODE_RUN && !supply_s_i && !batt_s_i) |=> (st_q.mode == MODE_HOLD));
    p_lock_gate_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.mode != MODE_RUN && !lock_s_i) |=> (st_q.mode != MODE_RUN));
    p_sleep_stay_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.mode == MODE_SLEEP && !supply_s_i && !rtc_wake_i) |=> (st_q.mode == MODE_SLEEP));
    p_boot_pulse_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.boot |=> !st_q.boot);
endmodule

// File: rtl/pms_dom_decode.sv
module pms_dom_decode
    import pms_pkg::*;
(
    input  pm_mode_e  mode_i,
    output dom_ctrl_t ctrl_o
);
    always_comb begin
        ctrl_o = '{afe_ce_en: 1'b0, cpu_en: 1'b0, cpu_clk_xtal: 1'b1,
                   cpu_rst: 1'b0, regs_dflt: 1'b0};
        unique case (mode_i)
            MODE_RUN: begin
                ctrl_o.afe_ce_en    = 1'b1;
                ctrl_o.cpu_en       = 1'b1;
                ctrl_o.cpu_clk_xtal = 1'b0;
            end
            MODE_BROWN: ctrl_o.cpu_en = 1'b1;
            MODE_SLEEP: ;
            MODE_HOLD: begin
                ctrl_o.cpu_rst   = 1'b1;
                ctrl_o.regs_dflt = 1'b1;
            end
            default: ctrl_o.cpu_rst = 1'b1;
        endcase
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int          HOLD_CYCLES = 4096,
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] BOOT_ADDR   = 16'h0000
) (
    input  logic              clk_xtal_i,
    input  logic              rst_pin_i,
    input  logic              supply_ok_i,
    input  logic              batt_ok_i,
    input  logic              pll_lock_i,
    input  logic              rtc_wake_i,
    input  logic              sw_sleep_i,
    output logic [1:0]        mode_o,
    output logic              afe_ce_en_o,
    output logic              cpu_en_o,
    output logic              cpu_clk_xtal_o,
    output logic              cpu_rst_o,
    output logic              regs_dflt_o,
    output logic              boot_vld_o,
    output logic [ADDR_W-1:0] boot_addr_o
);
    localparam int NFLAG = 3;

    logic [NFLAG-1:0] flags_raw, flags_s;
    logic             hold_done;
    pm_mode_e         mode;
    dom_ctrl_t        ctrl;

    assign flags_raw = {pll_lock_i, batt_ok_i, supply_ok_i};

    pms_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_xtal_i),
        .rst_i (rst_pin_i),
        .din_i (flags_raw),
        .dout_o(flags_s)
    );

    pms_rst_timer #(.LIMIT(HOLD_CYCLES)) u_timer (
        .clk_i (clk_xtal_i),
        .rst_i (rst_pin_i),
        .run_i (mode == MODE_HOLD),
        .done_o(hold_done)
    );

    pms_mode_fsm u_fsm (
        .clk_i      (clk_xtal_i),
        .rst_i      (rst_pin_i),
        .supply_s_i (flags_s[0]),
        .batt_s_i   (flags_s[1]),
        .lock_s_i   (flags_s[2]),
        .rtc_wake_i (rtc_wake_i),
        .sw_sleep_i (sw_sleep_i),
        .hold_done_i(hold_done),
        .mode_o     (mode),
        .boot_o     (boot_vld_o)
    );

    pms_dom_decode u_dec (
        .mode_i(mode),
        .ctrl_o(ctrl)
    );

    assign mode_o         = mode;
    assign afe_ce_en_o    = ctrl.afe_ce_en;
    assign cpu_en_o       = ctrl.cpu_en;
    assign cpu_clk_xtal_o = ctrl.cpu_clk_xtal;
    assign cpu_rst_o      = ctrl.cpu_rst;
    assign regs_dflt_o    = ctrl.regs_dflt;
    assign boot_addr_o    = ADDR_W'(BOOT_ADDR);

    // R1: the processor never runs while held in reset
    p_rst_excl_r1: assert property (@(posedge clk_xtal_i) disable iff (rst_pin_i)
        $fell(cpu_rst_o) |-> $past(hold_done));
endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
    logic clk = 1'b0;
    logic rst_pin, supply, batt, lock, wake, swsl;
    logic [1:0]  mode;
    logic        afe_en, cpu_en, clk_x, cpu_rst, rdflt, boot;
    logic [15:0] baddr;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_seq uut (
        .clk_xtal_i(clk), .rst_pin_i(rst_pin), .supply_ok_i(supply),
        .batt_ok_i(batt), .pll_lock_i(lock), .rtc_wake_i(wake),
        .sw_sleep_i(swsl), .mode_o(mode), .afe_ce_en_o(afe_en),
        .cpu_en_o(cpu_en), .cpu_clk_xtal_o(clk_x), .cpu_rst_o(cpu_rst),
        .regs_dflt_o(rdflt), .boot_vld_o(boot), .boot_addr_o(baddr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_pin_reset();
        rst_pin = 1; supply = 1; batt = 1; lock = 1; wake = 0; swsl = 0;
        cyc(3);
        chk("R1 mode", mode, 2'b11);
        chk("R1 cpu_rst", cpu_rst, 1);
        chk("R1 regs_dflt", rdflt, 1);
        chk("R1 enables", {afe_en, cpu_en}, 2'b00);
        rst_pin = 0;
        cyc(4095);
        chk("R2 still held at 4095", cpu_rst, 1);
        cyc(1);
        chk("R2 released at 4096", cpu_rst, 0);
        chk("R3 boot pulse", boot, 1);
        chk("R3 boot addr", baddr, 16'h0000);
        chk("R4 run outputs", {mode, afe_en, cpu_en, clk_x}, {2'b00, 3'b110});
        cyc(1);
        chk("R3 pulse single", boot, 0);
    endtask

    task automatic t_brownout();
        supply = 0;
        cyc(2);
        chk("R10 not yet at edge 2", mode, 2'b00);
        cyc(1);
        chk("R10 brownout at edge 3", mode, 2'b01);
        chk("R4 brown outputs", {afe_en, cpu_en, clk_x}, 3'b011);
    endtask

    task automatic t_lock_gate();
        lock = 0; supply = 1;
        cyc(10);
        chk("R8 blocked without lock", mode, 2'b01);
        lock = 1;
        cyc(2);
        chk("R8 R10 lock latency", mode, 2'b01);
        cyc(1);
        chk("R8 run after lock", mode, 2'b00);
    endtask

    task automatic t_sw_sleep();
        swsl = 1;
        cyc(3);
        chk("R9 ignored in run", mode, 2'b00);
        swsl = 0;
        supply = 0;
        cyc(4);
        chk("R4 brownout again", mode, 2'b01);
        swsl = 1;
        cyc(1);
        chk("R9 sleep next edge", mode, 2'b10);
        swsl = 0;
        chk("R6 sleep outputs", {afe_en, cpu_en}, 2'b00);
    endtask

    task automatic t_sleep_wake();
        cyc(10);
        chk("R7 sleep held", mode, 2'b10);
        wake = 1;
        cyc(1);
        wake = 0;
        chk("R7 wake to brownout", mode, 2'b01);
    endtask

    task automatic t_batt_loss();
        batt = 0;
        cyc(3);
        chk("R6 battery loss to sleep", mode, 2'b10);
        chk("R6 cpu off", cpu_en, 0);
        supply = 1; batt = 1;
        cyc(3);
        chk("R7 supply return to run", mode, 2'b00);
    endtask

    task automatic t_hold_entry();
        batt = 0;
        cyc(5);
        chk("R5 battery loss alone ignored", mode, 2'b00);
        supply = 0;
        cyc(3);
        chk("R5 reset hold entry", mode, 2'b11);
        chk("R5 cpu_rst", cpu_rst, 1);
        supply = 1; batt = 1;
        cyc(4095);
        chk("R5 held through window", cpu_rst, 1);
        cyc(1);
        chk("R5 released after window", {mode, cpu_rst}, 3'b000);
        chk("R3 boot after hold", boot, 1);
    endtask

    task automatic t_async_pin();
        cyc(2);
        #2 rst_pin = 1;
        #1 chk("R1 async entry", {mode, cpu_rst, rdflt}, 4'b1111);
        rst_pin = 0;
    endtask

    initial begin
        t_pin_reset();
        t_brownout();
        t_lock_gate();
        t_sw_sleep();
        t_sleep_wake();
        t_batt_loss();
        t_hold_entry();
        t_async_pin();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule